// File: doc/BRIEF.md
# Luma Quarter-Sample Interpolator

This block builds the 4x4 luma prediction for one motion-compensated block. The memory side supplies a 9x9 window of integer reference samples, already reordered so that the block's top-left integer sample sits two rows and two columns in from the window's corner. The block also takes the fractional part of the motion vector, two bits per axis. It returns sixteen 8-bit predicted samples.

Half positions come from the six-tap kernel (1, -5, 20, 20, -5, 1). The centre position cascades that kernel over unclipped horizontal intermediates. Quarter positions are rounded means of two neighbouring integer or half samples. All sixteen outputs are produced together. Stage one registers the integer and half samples and stage two registers the selected result, so a block is ready two clock edges after its window is accepted. The block accepts one window on every cycle.

Top module: `luma_qpel_interp`

## Requirements
- R1: While reset is held, and after its release until the first result, `out_valid` is 0 and `pred` is all zeros.
- R2: A window accepted with `in_valid` high at a rising edge appears on `pred`, with `out_valid` high, after the second following rising edge. `out_valid` is low two edges after any cycle with `in_valid` low, and back-to-back windows give back-to-back results.
- R3: `pred` keeps its last value whenever no new result is produced.
- R4: Window sample (row,col) sits at `win[(row*9+col)*8 +: 8]`. Output sample (r,c) of the block sits at `pred[(r*4+c)*8 +: 8]`. For `frac_x`=0 and `frac_y`=0, output (r,c) equals window sample (r+2,c+2).
- R5: For `frac_x`=2 and `frac_y`=0, output (r,c) is the horizontal half sample. The kernel is applied over window row r+2, columns c..c+5, then 16 is added, the sum is shifted right arithmetically by 5 and the result is clipped to 0..255. For `frac_x`=0 and `frac_y`=2, the same kernel runs down window column c+2, rows r..r+5.
- R6: For `frac_x`=2 and `frac_y`=2, output (r,c) is found in three steps. First, the unclipped horizontal kernel sums are taken on window rows r..r+5. Second, the vertical kernel is applied across those six sums. Third, 512 is added, the sum is shifted right by 10 and the result is clipped to 0..255.
- R7: The one-axis quarter positions average an integer sample with the half sample on that axis, using (x+y+1)>>1. (1,0) takes the integer sample and the horizontal half. (3,0) takes the integer sample to the right and the horizontal half. (0,1) takes the integer sample and the vertical half. (0,3) takes the integer sample below and the vertical half.
- R8: The quarter positions next to the centre average the centre sample with one half sample. (2,1) uses the horizontal half, and (2,3) uses the horizontal half one row down. (1,2) uses the vertical half, and (3,2) uses the vertical half one column right.
- R9: Each diagonal quarter position averages two half samples. (1,1) uses the horizontal and vertical halves. (3,1) uses the horizontal half and the right vertical half. (1,3) uses the vertical half and the lower horizontal half. (3,3) uses the right vertical half and the lower horizontal half.
- R10: Half and centre samples whose kernel result falls below 0 or above 255 saturate to 0 or 255 before any averaging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window and fraction are valid this cycle |
| frac_x | input | 2 | Horizontal quarter-sample fraction |
| frac_y | input | 2 | Vertical quarter-sample fraction |
| win | input | 648 | 9x9 integer reference window, row-major |
| out_valid | output | 1 | `pred` carries a new block this cycle |
| pred | output | 128 | 4x4 predicted block, row-major |

## Verification
A flat window must return its own value at all sixteen fractions, which isolates kernel gain and rounding from sample selection. Random windows swept over every fraction catch a wrong neighbour choice, a swapped axis or a misplaced tap. Checkerboards and hard vertical edges push the kernel outside 0..255, which exposes missing saturation and any clipping of the centre's intermediate sums. Valid gaps and back-to-back streams separate the two-edge latency from the hold behaviour of `pred`.

// File: rtl/luma_qpel_interp.sv
module luma_qpel_interp #(
  parameter int PW  = 8,
  parameter int BLK = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [1:0]                     frac_x,
  input  logic [1:0]                     frac_y,
  input  logic [(BLK+5)*(BLK+5)*PW-1:0]  win,
  output logic                           out_valid,
  output logic [BLK*BLK*PW-1:0]          pred
);

  localparam int WIN = BLK + 5;
  localparam int NP  = BLK * BLK;
  localparam int AW  = 2 * PW + 8;

  typedef logic signed [AW-1:0] acc_t;

  function automatic acc_t ext(input logic [PW-1:0] p);
    return acc_t'({{(AW-PW){1'b0}}, p});
  endfunction

  function automatic acc_t tap6(input acc_t p0, input acc_t p1, input acc_t p2,
                                input acc_t p3, input acc_t p4, input acc_t p5);
    acc_t mid, outer;
    mid   = p2 + p3;
    outer = p1 + p4;
    return p0 + p5 + (mid <<< 4) + (mid <<< 2) - (outer <<< 2) - outer;
  endfunction

  function automatic logic [PW-1:0] clip(input acc_t v);
    if (v[AW-1])            return '0;
    else if (|v[AW-2:PW])   return '1;
    else                    return v[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] avg(input logic [PW-1:0] a, input logic [PW-1:0] b);
    logic [PW:0] t;
    t = {1'b0, a} + {1'b0, b} + {{PW{1'b0}}, 1'b1};
    return t[PW:1];
  endfunction

  logic [PW-1:0] pix [WIN][WIN];
  logic          v1;
  logic [1:0]    fx1, fy1;
  logic [NP*PW-1:0] qflat, gflat, bflat;

  for (genvar gr = 0; gr < WIN; gr++) begin : g_row
    for (genvar gc = 0; gc < WIN; gc++) begin : g_col
      assign pix[gr][gc] = win[(gr*WIN+gc)*PW +: PW];
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      fx1 <= frac_x;
      fy1 <= frac_y;
    end
  end

  for (genvar r = 0; r < BLK; r++) begin : g_br
    for (genvar c = 0; c < BLK; c++) begin : g_bc
      localparam int P = r * BLK + c;
      acc_t hr [6];
      acc_t vl, vr, jraw;
      logic [PW-1:0] gi, ri, di, hb, hs, vh, vm, jc, q;

      for (genvar k = 0; k < 6; k++) begin : g_k
        assign hr[k] = tap6(ext(pix[r+k][c]),   ext(pix[r+k][c+1]), ext(pix[r+k][c+2]),
                            ext(pix[r+k][c+3]), ext(pix[r+k][c+4]), ext(pix[r+k][c+5]));
      end
      assign vl = tap6(ext(pix[r][c+2]),   ext(pix[r+1][c+2]), ext(pix[r+2][c+2]),
                       ext(pix[r+3][c+2]), ext(pix[r+4][c+2]), ext(pix[r+5][c+2]));
      assign vr = tap6(ext(pix[r][c+3]),   ext(pix[r+1][c+3]), ext(pix[r+2][c+3]),
                       ext(pix[r+3][c+3]), ext(pix[r+4][c+3]), ext(pix[r+5][c+3]));
      assign jraw = tap6(hr[0], hr[1], hr[2], hr[3], hr[4], hr[5]);

      always_ff @(posedge clk) begin
        if (in_valid) begin
          gi <= pix[r+2][c+2];
          ri <= pix[r+2][c+3];
          di <= pix[r+3][c+2];
          hb <= clip((hr[2] + acc_t'(16)) >>> 5);
          hs <= clip((hr[3] + acc_t'(16)) >>> 5);
          vh <= clip((vl + acc_t'(16)) >>> 5);
          vm <= clip((vr + acc_t'(16)) >>> 5);
          jc <= clip((jraw + acc_t'(512)) >>> 10);
        end
      end

      always_comb begin
        case ({fy1, fx1})
          4'b0000: q = gi;
          4'b0001: q = avg(gi, hb);
          4'b0010: q = hb;
          4'b0011: q = avg(ri, hb);
          4'b0100: q = avg(gi, vh);
          4'b0101: q = avg(hb, vh);
          4'b0110: q = avg(hb, jc);
          4'b0111: q = avg(hb, vm);
          4'b1000: q = vh;
          4'b1001: q = avg(vh, jc);
          4'b1010: q = jc;
          4'b1011: q = avg(jc, vm);
          4'b1100: q = avg(di, vh);
          4'b1101: q = avg(vh, hs);
          4'b1110: q = avg(jc, hs);
          default: q = avg(vm, hs);
        endcase
      end

      assign qflat[P*PW +: PW] = q;
      assign gflat[P*PW +: PW] = gi;
      assign bflat[P*PW +: PW] = hb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      out_valid <= 1'b0;
      pred      <= '0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
      if (v1) pred <= qflat;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(pred));

  assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && fx1 == 2'd0 && fy1 == 2'd0) |=> pred == $past(gflat));

  assert_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && fx1 == 2'd2 && fy1 == 2'd0) |=> pred == $past(bflat));

endmodule

// File: tb/luma_qpel_interp_bench.sv
`timescale 1ns/1ps
module luma_qpel_interp_bench;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   frac_x = '0;
  logic [1:0]   frac_y = '0;
  logic [W*W*8-1:0] win = '0;
  logic         out_valid;
  logic [127:0] pred;

  luma_qpel_interp u_luma_qpel_interp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frac_x(frac_x),
    .frac_y(frac_y), .win(win), .out_valid(out_valid), .pred(pred));

  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int w [W][W];
  bit           q_v [$];
  logic [127:0] q_p [$];
  string        q_t [$];
  logic [127:0] last_pred = '0;

  function automatic int h6(int a, int b, int c, int d, int e, int f);
    return a - 5*b + 20*c + 20*d - 5*e + f;
  endfunction

  function automatic int clp(int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  function automatic int av(int a, int b);
    return (a + b + 1) / 2;
  endfunction

  function automatic int ref_px(int r, int c, int fx, int fy);
    int hr [6];
    int gi, ri, di, hb, hs, vh, vm, jc;
    for (int k = 0; k < 6; k++)
      hr[k] = h6(w[r+k][c], w[r+k][c+1], w[r+k][c+2], w[r+k][c+3], w[r+k][c+4], w[r+k][c+5]);
    gi = w[r+2][c+2]; ri = w[r+2][c+3]; di = w[r+3][c+2];
    hb = clp((hr[2] + 16) >>> 5);
    hs = clp((hr[3] + 16) >>> 5);
    vh = clp((h6(w[r][c+2], w[r+1][c+2], w[r+2][c+2], w[r+3][c+2], w[r+4][c+2], w[r+5][c+2]) + 16) >>> 5);
    vm = clp((h6(w[r][c+3], w[r+1][c+3], w[r+2][c+3], w[r+3][c+3], w[r+4][c+3], w[r+5][c+3]) + 16) >>> 5);
    jc = clp((h6(hr[0], hr[1], hr[2], hr[3], hr[4], hr[5]) + 512) >>> 10);
    case (fy*4 + fx)
      0:  return gi;
      1:  return av(gi, hb);
      2:  return hb;
      3:  return av(ri, hb);
      4:  return av(gi, vh);
      5:  return av(hb, vh);
      6:  return av(hb, jc);
      7:  return av(hb, vm);
      8:  return vh;
      9:  return av(vh, jc);
      10: return jc;
      11: return av(jc, vm);
      12: return av(di, vh);
      13: return av(vh, hs);
      14: return av(jc, hs);
      default: return av(vm, hs);
    endcase
  endfunction

  function automatic string tag_of(int fx, int fy);
    if (fx == 0 && fy == 0) return "R4";
    if ((fx == 2 && fy == 0) || (fx == 0 && fy == 2)) return "R5";
    if (fx == 2 && fy == 2) return "R6";
    if (fx == 0 || fy == 0) return "R7";
    if (fx == 2 || fy == 2) return "R8";
    return "R9";
  endfunction

  task automatic check_out();
    bit ev; logic [127:0] ep; string et;
    if (q_v.size() < 2) return;
    ev = q_v.pop_front(); ep = q_p.pop_front(); et = q_t.pop_front();
    n_tests++;
    if (out_valid !== ev) begin
      n_fail++;
      $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, ev);
    end
    if (!ev) ep = last_pred;
    else last_pred = ep;
    n_tests++;
    if (pred !== ep) begin
      n_fail++;
      for (int p = 0; p < 16; p++)
        if (pred[p*8 +: 8] !== ep[p*8 +: 8]) begin
          $display("FAIL %s pixel %0d actual %0d expected %0d",
                   ev ? et : "R3", p, pred[p*8 +: 8], ep[p*8 +: 8]);
          break;
        end
    end
  endtask

  task automatic step(input bit v, input int fx, input int fy, input string extra);
    logic [127:0] e;
    @(negedge clk);
    check_out();
    in_valid = v; frac_x = fx[1:0]; frac_y = fy[1:0];
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++) win[(r*W+c)*8 +: 8] = w[r][c][7:0];
    e = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) e[(r*4+c)*8 +: 8] = ref_px(r, c, fx, fy);
    q_v.push_back(v); q_p.push_back(e); q_t.push_back({extra, tag_of(fx, fy)});
  endtask

  task automatic fill(input int kind, input int val);
    for (int r = 0; r < W; r++)
      for (int c = 0; c < W; c++)
        case (kind)
          0: w[r][c] = val;
          1: w[r][c] = int'($urandom_range(0, 255));
          2: w[r][c] = ((r + c) % 2 == 1) ? 255 : 0;
          3: w[r][c] = (c >= 4) ? 255 : 0;
          4: w[r][c] = (r * 29 + c * 13) % 256;
          default: w[r][c] = ((r + c) % 2 == 1) ? 0 : 255;
        endcase
  endtask

  task automatic sweep(input string extra);
    for (int fy = 0; fy < 4; fy++)
      for (int fx = 0; fx < 4; fx++) step(1'b1, fx, fy, extra);
  endtask

  initial begin
    fill(0, 0);
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0 || pred !== '0) begin
      n_fail++;
      $display("FAIL R1 reset state actual %0b/%h expected 0/0", out_valid, pred);
    end
    rst_n = 1'b1;
    q_v.push_back(1'b0); q_p.push_back('0); q_t.push_back("R1");
    q_v.push_back(1'b0); q_p.push_back('0); q_t.push_back("R1");
    step(1'b0, 0, 0, "");
    step(1'b0, 0, 0, "");
    fill(0, 137); sweep("");
    fill(0, 0);   sweep("");
    fill(0, 255); sweep("");
    fill(4, 0);   sweep("");
    for (int i = 0; i < 6; i++) begin fill(1, 0); sweep(""); end
    fill(2, 0); sweep("R10 ");
    fill(5, 0); sweep("R10 ");
    fill(3, 0); sweep("R10 ");
    fill(1, 0);
    step(1'b1, 3, 1, ""); step(1'b0, 1, 1, ""); step(1'b0, 2, 2, ""); step(1'b0, 0, 0, "");
    for (int i = 0; i < 300; i++) begin
      if (i % 7 == 0) fill(1, 0);
      step(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), "");
    end
    step(1'b0, 0, 0, ""); step(1'b0, 0, 0, ""); step(1'b0, 0, 0, "");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule